// File: doc/BRIEF.md
# Staged Configuration Register Bank with Commit Strobe

This block holds the configuration registers of a converter-style device behind a byte-wide parallel access port. An upstream serial-interface front end does the bit-level protocol. It then presents an address, a write strobe and a data byte. The bank answers each read combinationally with the addressed byte. The current active settings are driven as parallel buses to downstream logic.

Most registers are staged, and a write to one only changes its shadow copy. Writing the key value 0x01 to the commit address 0xFF copies every shadow byte into its active copy on that clock edge. All staged settings therefore change together. Four addresses (0x00, 0x02, 0x04, 0x05) have a single stage and take a write at once. One bit of the active bank, bit 0 of address 0x09, is also brought out on its own as the enable for a clock duty-cycle stabilizer.

Top module: `cfg_commit_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every staged register at 0x08..0x2D reads and drives 0x00 except 0x09, which is 0x01. The immediate registers hold 0x00=0x18, 0x02=0x00, 0x04=0x0F and 0x05=0x3F, and `stab_en` is 1.
- R2: A write to a staged address (0x08..0x2D) leaves `act_regs` unchanged until a commit occurs.
- R3: A write of 0x01 to 0xFF loads every shadow byte into its active copy at that clock edge. `commit_pulse` is then 1 for exactly the following cycle.
- R4: A write to 0xFF of any value other than 0x01 causes no commit and changes no output.
- R5: A write to an immediate address (0x00, 0x02, 0x04, 0x05) appears on `imm_regs` at that clock edge, with no commit needed.
- R6: Reading a staged address returns its shadow value, which is the most recently written byte, even before a commit.
- R7: Reading address 0xFF always returns 0x00.
- R8: Writes to unimplemented addresses (0x01, 0x03, 0x06, 0x07, 0x2E..0xFE) change nothing, and reads of them return 0x00.
- R9: `stab_en` equals bit 0 of the active copy of 0x09. Clearing that bit in the shadow leaves `stab_en` at 1 until a commit, after which it reads 0.
- R10: Byte i of `act_regs` (bits 8i+7..8i) is the active value of address 0x08+i. Bytes 0..3 of `imm_regs` are addresses 0x00, 0x02, 0x04 and 0x05 in that order. Within each byte, bit 7 is the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| act_regs | output | 304 | Active values of staged registers 0x08..0x2D, one byte each |
| imm_regs | output | 32 | Values of immediate registers 0x00, 0x02, 0x04, 0x05 |
| stab_en | output | 1 | Duty-cycle stabilizer enable (active 0x09 bit 0) |
| commit_pulse | output | 1 | High for one cycle after a commit |

## Verification
The embedded properties check on every cycle that the active bank holds its value unless a commit strobe came in, and that a commit copies the prior shadow contents. They also check that an immediate write lands at once, and that reads of 0xFF and of unmapped addresses return zero. They further check that a fall of `stab_en` is always caused by a commit. Only the bench's scenarios can show the user-visible sequences: the exact default values, shadow-versus-active readback before a commit, that non-key commit writes are inert, and the byte packing of the output buses. A behavioural model in the bench is compared with every output on every clock.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  localparam int DW    = 8;
  localparam int AW    = 8;
  localparam int IMM_N = 4;

  // address of immediate slot k (order fixes imm_regs packing)
  function automatic logic [AW-1:0] imm_addr(input int k);
    case (k)
      0:       return 8'h00;
      1:       return 8'h02;
      2:       return 8'h04;
      default: return 8'h05;
    endcase
  endfunction

  function automatic logic [DW-1:0] imm_dflt(input int k);
    case (k)
      0:       return 8'h18;
      1:       return 8'h00;
      2:       return 8'h0F;
      default: return 8'h3F;
    endcase
  endfunction

  // staged register defaults: only the stabilizer register is nonzero
  function automatic logic [DW-1:0] buf_dflt(input int a);
    return (a == 9) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_bank_pkg::*;
#(
  parameter int             BUF_LO    = 8,
  parameter int             BUF_N     = 38,
  parameter logic [AW-1:0]  XFER_ADDR = 8'hFF,
  parameter logic [DW-1:0]  XFER_KEY  = 8'h01
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [BUF_N-1:0] buf_sel_o,
  output logic [IMM_N-1:0] imm_sel_o,
  output logic             commit_o,
  output logic             hit_o
);

  for (genvar i = 0; i < BUF_N; i++) begin : g_bsel
    assign buf_sel_o[i] = (addr_i == AW'(BUF_LO + i));
  end

  for (genvar k = 0; k < IMM_N; k++) begin : g_isel
    assign imm_sel_o[k] = (addr_i == imm_addr(k));
  end

  assign commit_o = wr_i && (addr_i == XFER_ADDR) && (wdata_i == XFER_KEY);
  assign hit_o    = (|buf_sel_o) || (|imm_sel_o) || (addr_i == XFER_ADDR);

  // at most one register selected at a time (R8: no aliasing onto a neighbour)
  always_comb begin
    p_sel_unique_r8: assert ($onehot0({buf_sel_o, imm_sel_o}));
  end

endmodule

// File: rtl/cfg_buf_bank.sv
module cfg_buf_bank
  import cfg_bank_pkg::*;
#(
  parameter int BUF_LO = 8,
  parameter int BUF_N  = 38
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BUF_N-1:0]    we_i,
  input  logic [BUF_N-1:0]    sel_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                commit_i,
  output logic [BUF_N*DW-1:0] act_o,
  output logic [DW-1:0]       rd_o
);

  localparam int FW = BUF_N * DW;

  logic [DW-1:0] mst_q [BUF_N];
  logic [DW-1:0] act_q [BUF_N];
  logic [DW-1:0] mst_d [BUF_N];
  logic [DW-1:0] act_d [BUF_N];
  logic [FW-1:0] mst_flat;

  for (genvar i = 0; i < BUF_N; i++) begin : g_reg
    localparam logic [DW-1:0] DFLT = buf_dflt(BUF_LO + i);

    always_comb begin
      mst_d[i] = wdata_i;
      act_d[i] = mst_q[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mst_q[i] <= DFLT;
        act_q[i] <= DFLT;
      end else begin
        if (we_i[i])  mst_q[i] <= mst_d[i];
        if (commit_i) act_q[i] <= act_d[i];
      end
    end

    assign act_o[i*DW +: DW]    = act_q[i];
    assign mst_flat[i*DW +: DW] = mst_q[i];
  end

  // shadow readback through an AND-OR mux
  always_comb begin
    rd_o = '0;
    for (int i = 0; i < BUF_N; i++) begin
      rd_o = rd_o | (sel_i[i] ? mst_q[i] : '0);
    end
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_o));

  p_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (act_o == $past(mst_flat)));

endmodule

// File: rtl/cfg_imm_bank.sv
module cfg_imm_bank
  import cfg_bank_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IMM_N-1:0]    we_i,
  input  logic [IMM_N-1:0]    sel_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [IMM_N*DW-1:0] val_o,
  output logic [DW-1:0]       rd_o
);

  logic [DW-1:0] val_q [IMM_N];
  logic [DW-1:0] val_d [IMM_N];

  for (genvar k = 0; k < IMM_N; k++) begin : g_reg
    localparam logic [DW-1:0] DFLT = imm_dflt(k);

    always_comb val_d[k] = wdata_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      val_q[k] <= DFLT;
      else if (we_i[k]) val_q[k] <= val_d[k];
    end

    assign val_o[k*DW +: DW] = val_q[k];

    p_imm_now_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[k] |=> (val_o[k*DW +: DW] == $past(wdata_i)));
  end

  always_comb begin
    rd_o = '0;
    for (int k = 0; k < IMM_N; k++) begin
      rd_o = rd_o | (sel_i[k] ? val_q[k] : '0);
    end
  end

endmodule

// File: rtl/cfg_commit_bank.sv
module cfg_commit_bank
  import cfg_bank_pkg::*;
#(
  parameter int            BUF_LO    = 8,
  parameter int            BUF_N     = 38,
  parameter int            DCS_ADDR  = 9,
  parameter logic [AW-1:0] XFER_ADDR = 8'hFF,
  parameter logic [DW-1:0] XFER_KEY  = 8'h01,
  localparam int           ACT_W     = BUF_N * DW,
  localparam int           IMM_W     = IMM_N * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [ACT_W-1:0] act_regs,
  output logic [IMM_W-1:0] imm_regs,
  output logic             stab_en,
  output logic             commit_pulse
);

  localparam int DCS_IDX = DCS_ADDR - BUF_LO;

  logic [1:0]       rst_sync_q;
  logic             rst_s;
  logic [BUF_N-1:0] buf_sel;
  logic [IMM_N-1:0] imm_sel;
  logic             commit;
  logic             hit;
  logic [DW-1:0]    buf_rd;
  logic [DW-1:0]    imm_rd;
  logic             pulse_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  cfg_addr_decode #(
    .BUF_LO(BUF_LO), .BUF_N(BUF_N), .XFER_ADDR(XFER_ADDR), .XFER_KEY(XFER_KEY)
  ) u_dec (
    .addr_i(bus_addr), .wr_i(bus_wr), .wdata_i(bus_wdata),
    .buf_sel_o(buf_sel), .imm_sel_o(imm_sel), .commit_o(commit), .hit_o(hit)
  );

  cfg_buf_bank #(.BUF_LO(BUF_LO), .BUF_N(BUF_N)) u_buf (
    .clk_i(clk), .rst_ni(rst_s),
    .we_i(buf_sel & {BUF_N{bus_wr}}), .sel_i(buf_sel),
    .wdata_i(bus_wdata), .commit_i(commit),
    .act_o(act_regs), .rd_o(buf_rd)
  );

  cfg_imm_bank u_imm (
    .clk_i(clk), .rst_ni(rst_s),
    .we_i(imm_sel & {IMM_N{bus_wr}}), .sel_i(imm_sel),
    .wdata_i(bus_wdata), .val_o(imm_regs), .rd_o(imm_rd)
  );

  // transfer bit: set by a commit, self-clears next cycle
  always_comb pulse_d = commit;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) commit_pulse <= 1'b0;
    else        commit_pulse <= pulse_d;
  end

  assign bus_rdata = buf_rd | imm_rd;
  assign stab_en   = act_regs[DCS_IDX*DW];

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_s)
    commit |=> commit_pulse);

  p_xfer_rd_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr == XFER_ADDR) |-> (bus_rdata == '0));

  p_miss_rd_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !hit |-> (bus_rdata == '0));

  p_stab_fall_r9: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(stab_en) |-> $past(commit));

endmodule

// File: tb/cfg_commit_bank_test.sv
`timescale 1ns/1ps
module cfg_commit_bank_test;

  localparam int BUF_LO = 8;
  localparam int BUF_N  = 38;
  localparam int AW_W   = BUF_N * 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [7:0]      bus_addr;
  logic            bus_wr;
  logic [7:0]      bus_wdata;
  logic [7:0]      bus_rdata;
  logic [AW_W-1:0] act_regs;
  logic [31:0]     imm_regs;
  logic            stab_en;
  logic            commit_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  cfg_commit_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_regs(act_regs),
    .imm_regs(imm_regs), .stab_en(stab_en), .commit_pulse(commit_pulse)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] m_mst [256];
  logic [7:0] m_act [256];
  logic [7:0] m_imm [256];
  logic       m_pulse;

  function automatic bit is_buf(input int a);
    return (a >= 8'h08) && (a <= 8'h2D);
  endfunction
  function automatic bit is_imm(input int a);
    return (a == 0) || (a == 2) || (a == 4) || (a == 5);
  endfunction

  task automatic model_defaults();
    for (int a = 0; a < 256; a++) begin
      m_mst[a] = (a == 9) ? 8'h01 : 8'h00;
      m_act[a] = m_mst[a];
      m_imm[a] = 8'h00;
    end
    m_imm[0] = 8'h18; m_imm[2] = 8'h00; m_imm[4] = 8'h0F; m_imm[5] = 8'h3F;
    m_pulse = 1'b0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_defaults();
    else begin
      m_pulse <= 1'b0;
      if (bus_wr) begin
        if (bus_addr == 8'hFF && bus_wdata == 8'h01) begin
          for (int a = 0; a < 256; a++) m_act[a] <= m_mst[a];
          m_pulse <= 1'b1;
        end
        if (is_buf(bus_addr)) m_mst[bus_addr] <= bus_wdata;
        if (is_imm(bus_addr)) m_imm[bus_addr] <= bus_wdata;
      end
    end
  end

  function automatic logic [7:0] exp_read(input int a);
    if (is_buf(a)) return m_mst[a];
    if (is_imm(a)) return m_imm[a];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [AW_W-1:0] got, input logic [AW_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      logic [AW_W-1:0] ea;
      for (int i = 0; i < BUF_N; i++) ea[i*8 +: 8] = m_act[BUF_LO + i];
      chk("R3 act_regs", act_regs, ea);
      chk("R5 imm_regs", AW_W'(imm_regs), AW_W'({m_imm[5], m_imm[4], m_imm[2], m_imm[0]}));
      chk("R6 bus_rdata", AW_W'(bus_rdata), AW_W'(exp_read(bus_addr)));
      chk("R9 stab_en", AW_W'(stab_en), AW_W'(m_act[9][0]));
      chk("R3 commit_pulse", AW_W'(commit_pulse), AW_W'(m_pulse));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    chk(req, AW_W'(bus_rdata), AW_W'(exp));
  endtask

  function automatic logic [7:0] act_byte(input int a);
    return act_regs[(a - BUF_LO)*8 +: 8];
  endfunction

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [AW_W-1:0] snap_act;
  logic [31:0]     snap_imm;

  initial begin
    rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_wdata = 8'h00;
    model_defaults();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 / R10 reset state
    @(negedge clk);
    chk("R1 act 0x09 default", AW_W'(act_byte(9)), AW_W'(8'h01));
    chk("R1 act 0x08 default", AW_W'(act_byte(8)), AW_W'(8'h00));
    chk("R10 imm packing default", AW_W'(imm_regs), AW_W'(32'h3F0F0018));
    chk("R1 stab_en default", AW_W'(stab_en), AW_W'(1'b1));
    rd_chk("R1 read 0x09", 8'h09, 8'h01);

    // R9 / R2 / R6: clear stabilizer bit, staged only
    wr(8'h09, 8'h00);
    @(negedge clk);
    chk("R9 stab_en before commit", AW_W'(stab_en), AW_W'(1'b1));
    chk("R2 act 0x09 held", AW_W'(act_byte(9)), AW_W'(8'h01));
    chk("R6 read shadow 0x09", AW_W'(bus_rdata), AW_W'(8'h00));

    // R4 non-key commit write
    wr(8'hFF, 8'h02);
    @(negedge clk);
    chk("R4 no pulse", AW_W'(commit_pulse), AW_W'(1'b0));
    chk("R4 stab_en unchanged", AW_W'(stab_en), AW_W'(1'b1));
    wr(8'hFF, 8'h81);
    @(negedge clk);
    chk("R4 act unchanged", AW_W'(act_byte(9)), AW_W'(8'h01));

    // R3 / R9 / R7 commit
    wr(8'hFF, 8'h01);
    @(negedge clk);
    chk("R3 pulse after commit", AW_W'(commit_pulse), AW_W'(1'b1));
    chk("R9 stab_en after commit", AW_W'(stab_en), AW_W'(1'b0));
    chk("R7 read 0xFF", AW_W'(bus_rdata), AW_W'(8'h00));
    @(negedge clk);
    chk("R3 pulse self-clears", AW_W'(commit_pulse), AW_W'(1'b0));

    // R10 packing of staged bank, several writes then one commit
    wr(8'h08, 8'hA5);
    wr(8'h2D, 8'h5A);
    wr(8'h10, 8'h3C);
    @(negedge clk);
    chk("R2 act 0x2D held", AW_W'(act_byte(8'h2D)), AW_W'(8'h00));
    wr(8'hFF, 8'h01);
    @(negedge clk);
    chk("R10 byte0 is 0x08", AW_W'(act_regs[7:0]), AW_W'(8'hA5));
    chk("R10 byte37 is 0x2D", AW_W'(act_regs[37*8 +: 8]), AW_W'(8'h5A));
    chk("R3 act 0x10", AW_W'(act_byte(8'h10)), AW_W'(8'h3C));

    // R5 immediate write
    wr(8'h04, 8'h77);
    @(negedge clk);
    chk("R5 imm 0x04 at once", AW_W'(imm_regs[23:16]), AW_W'(8'h77));
    wr(8'h00, 8'hC3);
    @(negedge clk);
    chk("R5 imm 0x00 at once", AW_W'(imm_regs[7:0]), AW_W'(8'hC3));
    rd_chk("R5 read 0x04", 8'h04, 8'h77);

    // R8 unimplemented addresses
    @(negedge clk);
    snap_act = act_regs; snap_imm = imm_regs;
    wr(8'h01, 8'hFF); wr(8'h03, 8'hFF); wr(8'h2E, 8'hFF); wr(8'h80, 8'hFF); wr(8'h07, 8'hFF);
    wr(8'hFF, 8'h01);
    @(negedge clk);
    chk("R8 act untouched", act_regs, snap_act);
    chk("R8 imm untouched", AW_W'(imm_regs), AW_W'(snap_imm));
    rd_chk("R8 read 0x01", 8'h01, 8'h00);
    rd_chk("R8 read 0x2E", 8'h2E, 8'h00);
    rd_chk("R8 read 0xFE", 8'hFE, 8'h00);

    // R6 shadow readback differs from active
    wr(8'h08, 8'h11);
    @(negedge clk);
    chk("R6 read new shadow 0x08", AW_W'(bus_rdata), AW_W'(8'h11));
    chk("R2 act 0x08 still old", AW_W'(act_regs[7:0]), AW_W'(8'hA5));

    // R1 mid-run reset restores defaults
    do_reset();
    @(negedge clk);
    chk("R1 act 0x08 after reset", AW_W'(act_byte(8)), AW_W'(8'h00));
    chk("R1 stab_en after reset", AW_W'(stab_en), AW_W'(1'b1));
    chk("R1 imm after reset", AW_W'(imm_regs), AW_W'(32'h3F0F0018));
    rd_chk("R1 read 0x08 after reset", 8'h08, 8'h00);

    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule